// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational unit decides where a 32-bit integer core fetches next after a control-transfer instruction. It takes the current program counter, the two source register values, an immediate that has already been decoded and sign-extended, a two-bit control class and the three-bit branch condition code. From these it produces the next program counter, the return-address (link) value, a taken flag, a flag for a target that is not 4-byte aligned, and a flag for an unknown branch condition code.

The unit sits in the execute stage. Conditional branches compare the two register operands as equal, not equal, signed less-than, signed greater-or-equal, unsigned less-than or unsigned greater-or-equal. The offset is added to the PC. A direct jump always goes to PC plus offset. A register-indirect jump goes to rs1 plus immediate. Bit 0 of every computed target is cleared. The core has no delay slot, so the taken flag alone tells the fetch logic to discard the fall-through instruction. An alignment fault is reported only for a transfer that is actually taken.

Top module: `bju_next_pc`

## Requirements
- R1: With ctrlClass = 2'b00 (sequential), nextPc = pcIn + 4, and taken, addrMisaligned and condIllegal are all 0.
- R2: With ctrlClass = 2'b01 (branch), brFunc3 = 3'b000 is taken when rs1Val equals rs2Val, and brFunc3 = 3'b001 is taken when they differ.
- R3: brFunc3 = 3'b100 is taken when rs1Val < rs2Val as signed values, and brFunc3 = 3'b101 is taken when rs1Val >= rs2Val as signed values.
- R4: brFunc3 = 3'b110 is taken when rs1Val < rs2Val as unsigned values, and brFunc3 = 3'b111 is taken when rs1Val >= rs2Val as unsigned values.
- R5: A taken branch gives nextPc = (pcIn + immVal) with bit 0 cleared. A branch that is not taken gives nextPc = pcIn + 4.
- R6: With ctrlClass = 2'b10 (direct jump), taken = 1 and nextPc = (pcIn + immVal) with bit 0 cleared.
- R7: With ctrlClass = 2'b11 (register jump), taken = 1 and nextPc = (rs1Val + immVal) with bit 0 cleared.
- R8: linkVal equals pcIn + 4 (modulo 2^32) for every class.
- R9: addrMisaligned = 1 exactly when taken = 1 and nextPc[1:0] is not 2'b00.
- R10: When taken = 0, addrMisaligned is 0, even if the offset is not aligned.
- R11: With ctrlClass = 2'b01 and brFunc3 equal to 3'b010 or 3'b011, condIllegal = 1, taken = 0 and nextPc = pcIn + 4. In every other case condIllegal = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcIn | input | 32 | Address of the current instruction |
| rs1Val | input | 32 | First source operand |
| rs2Val | input | 32 | Second source operand |
| immVal | input | 32 | Decoded, sign-extended immediate |
| ctrlClass | input | 2 | 00 sequential, 01 branch, 10 direct jump, 11 register jump |
| brFunc3 | input | 3 | Branch condition code |
| nextPc | output | 32 | Address to fetch next |
| linkVal | output | 32 | Return address, pcIn + 4 |
| taken | output | 1 | Control transfer redirects fetch |
| addrMisaligned | output | 1 | Taken target is not 4-byte aligned |
| condIllegal | output | 1 | Unknown branch condition code |

## Verification
The bench drives operand pairs where signed and unsigned order disagree, such as 0x80000000 against 1. A design that swapped the signed and unsigned comparators would take the wrong path on exactly these pairs. Equal operands test the boundary of less-than against greater-or-equal. Register-jump sums that end in an odd bit check that bit 0 is cleared, and a design that left it set would produce odd fetch addresses. Offsets that land on a halfword are applied to both taken and not-taken branches, so a design that raised the alignment flag without qualifying it by taken would be caught. The two reserved condition codes are checked to make sure they neither redirect nor stay silent. Addition that wraps past 2^32 is also covered, for both the link value and the targets.

// File: rtl/bju_pkg.sv
package bju_pkg;

  typedef enum logic [1:0] {
    CLS_SEQ    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_JUMP   = 2'b10,
    CLS_REGJMP = 2'b11
  } ctrl_class_e;

  typedef enum logic [2:0] {
    CND_EQ  = 3'b000,
    CND_NE  = 3'b001,
    CND_LT  = 3'b100,
    CND_GE  = 3'b101,
    CND_LTU = 3'b110,
    CND_GEU = 3'b111
  } cond_code_e;

  // comparator results handed from datapath to control
  typedef struct packed {
    logic eq;
    logic ltSigned;
    logic ltUnsigned;
  } cmp_flags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeTarget;
    logic useRegBase;
  } bju_strobes_t;

endpackage

// File: rtl/bju_datapath.sv
module bju_datapath
  import bju_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  logic [XLEN-1:0] immVal,
  input  bju_strobes_t    strobes,
  output cmp_flags_t      cmpFlags,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkVal,
  output logic            addrMisaligned
);

  localparam int ALIGN_BITS = $clog2(INSN_BYTES);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] targetBase;
  logic [XLEN-1:0] targetSum;
  logic [XLEN-1:0] targetPc;

  // operand comparison
  always_comb begin
    cmpFlags.eq         = (rs1Val == rs2Val);
    cmpFlags.ltSigned   = ($signed(rs1Val) < $signed(rs2Val));
    cmpFlags.ltUnsigned = (rs1Val < rs2Val);
  end

  // target and sequential address
  always_comb begin
    seqPc      = pcIn + STEP;
    targetBase = strobes.useRegBase ? rs1Val : pcIn;
    targetSum  = targetBase + immVal;
    targetPc   = {targetSum[XLEN-1:1], 1'b0};
  end

  assign linkVal        = seqPc;
  assign nextPc         = strobes.takeTarget ? targetPc : seqPc;
  assign addrMisaligned = strobes.takeTarget && (targetPc[ALIGN_BITS-1:0] != '0);

endmodule

// File: rtl/bju_control.sv
module bju_control
  import bju_pkg::*;
(
  input  logic [1:0]   ctrlClass,
  input  logic [2:0]   brFunc3,
  input  cmp_flags_t   cmpFlags,
  output bju_strobes_t strobes,
  output logic         taken,
  output logic         condIllegal
);

  logic condMet;
  logic condKnown;

  always_comb begin
    condMet   = 1'b0;
    condKnown = 1'b1;
    case (brFunc3)
      CND_EQ:  condMet = cmpFlags.eq;
      CND_NE:  condMet = !cmpFlags.eq;
      CND_LT:  condMet = cmpFlags.ltSigned;
      CND_GE:  condMet = !cmpFlags.ltSigned;
      CND_LTU: condMet = cmpFlags.ltUnsigned;
      CND_GEU: condMet = !cmpFlags.ltUnsigned;
      default: condKnown = 1'b0;
    endcase
  end

  always_comb begin
    strobes     = '0;
    condIllegal = 1'b0;
    unique case (ctrl_class_e'(ctrlClass))
      CLS_SEQ: ;
      CLS_BRANCH: begin
        condIllegal        = !condKnown;
        strobes.takeTarget = condKnown && condMet;
      end
      CLS_JUMP:   strobes.takeTarget = 1'b1;
      CLS_REGJMP: begin
        strobes.takeTarget = 1'b1;
        strobes.useRegBase = 1'b1;
      end
      default: ;
    endcase
  end

  assign taken = strobes.takeTarget;

endmodule

// File: rtl/bju_next_pc.sv
module bju_next_pc
  import bju_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  logic [XLEN-1:0] immVal,
  input  logic [1:0]      ctrlClass,
  input  logic [2:0]      brFunc3,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkVal,
  output logic            taken,
  output logic            addrMisaligned,
  output logic            condIllegal
);

  cmp_flags_t   cmpFlags;
  bju_strobes_t strobes;

  bju_control ctrl_i (
    .ctrlClass  (ctrlClass),
    .brFunc3    (brFunc3),
    .cmpFlags   (cmpFlags),
    .strobes    (strobes),
    .taken      (taken),
    .condIllegal(condIllegal)
  );

  bju_datapath #(
    .XLEN      (XLEN),
    .INSN_BYTES(INSN_BYTES)
  ) dp_i (
    .pcIn          (pcIn),
    .rs1Val        (rs1Val),
    .rs2Val        (rs2Val),
    .immVal        (immVal),
    .strobes       (strobes),
    .cmpFlags      (cmpFlags),
    .nextPc        (nextPc),
    .linkVal       (linkVal),
    .addrMisaligned(addrMisaligned)
  );

endmodule

// File: rtl/bju_next_pc_checker.sv
module bju_next_pc_checker #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] pcIn,
  input logic [XLEN-1:0] rs1Val,
  input logic [XLEN-1:0] immVal,
  input logic [1:0]      ctrlClass,
  input logic [XLEN-1:0] nextPc,
  input logic [XLEN-1:0] linkVal,
  input logic            taken,
  input logic            addrMisaligned,
  input logic            condIllegal
);

  logic [XLEN-1:0] seqAddr;
  assign seqAddr = pcIn + XLEN'(4);

  always_comb begin
    if (!$isunknown({pcIn, rs1Val, immVal, ctrlClass, nextPc, linkVal,
                     taken, addrMisaligned, condIllegal})) begin
      p_seq_fallthrough_r1: assert (ctrlClass != 2'b00 ||
                                    (nextPc == seqAddr && !taken && !condIllegal))
        else $error("sequential class redirected");
      p_jumps_taken_r6: assert (ctrlClass[1] == 1'b0 || taken)
        else $error("jump class not taken");
      p_regjmp_even_r7: assert (ctrlClass != 2'b11 || nextPc[0] == 1'b0)
        else $error("register jump target odd");
      p_link_r8: assert (linkVal == seqAddr)
        else $error("link value wrong");
      p_nt_aligned_r10: assert (taken || (!addrMisaligned && nextPc == seqAddr))
        else $error("not-taken flagged or redirected");
      p_illegal_quiet_r11: assert (!condIllegal || (!taken && ctrlClass == 2'b01))
        else $error("illegal condition redirected");
    end
  end

endmodule

bind bju_next_pc bju_next_pc_checker #(.XLEN(XLEN)) chk_i (
  .pcIn          (pcIn),
  .rs1Val        (rs1Val),
  .immVal        (immVal),
  .ctrlClass     (ctrlClass),
  .nextPc        (nextPc),
  .linkVal       (linkVal),
  .taken         (taken),
  .addrMisaligned(addrMisaligned),
  .condIllegal   (condIllegal)
);

// File: tb/bju_next_pc_tb_top.sv
module bju_next_pc_tb_top;

  logic        clk = 1'b0;
  logic [31:0] pcIn, rs1Val, rs2Val, immVal;
  logic [1:0]  ctrlClass;
  logic [2:0]  brFunc3;
  logic [31:0] nextPc, linkVal;
  logic        taken, addrMisaligned, condIllegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  bju_next_pc dut_i (
    .pcIn(pcIn), .rs1Val(rs1Val), .rs2Val(rs2Val), .immVal(immVal),
    .ctrlClass(ctrlClass), .brFunc3(brFunc3), .nextPc(nextPc),
    .linkVal(linkVal), .taken(taken), .addrMisaligned(addrMisaligned),
    .condIllegal(condIllegal)
  );

  // reference model
  function automatic logic refCond(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) < $signed(b);
      3'b101: return $signed(a) >= $signed(b);
      3'b110: return a < b;
      3'b111: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic refIllegal(input logic [1:0] c, input logic [2:0] f);
    return (c == 2'b01) && (f == 3'b010 || f == 3'b011);
  endfunction

  function automatic logic refTaken(input logic [1:0] c, input logic [2:0] f,
                                    input logic [31:0] a, input logic [31:0] b);
    if (c[1]) return 1'b1;
    if (c == 2'b01) return refCond(f, a, b);
    return 1'b0;
  endfunction

  function automatic logic [31:0] refNext(input logic [1:0] c, input logic [2:0] f,
      input logic [31:0] pc, input logic [31:0] a, input logic [31:0] b, input logic [31:0] imm);
    logic [31:0] t;
    if (!refTaken(c, f, a, b)) return pc + 32'd4;
    t = (c == 2'b11) ? a + imm : pc + imm;
    return t & ~32'd1;
  endfunction

  task automatic checkBit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic checkWord(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [2:0] f, input logic [31:0] pc,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] imm);
    @(posedge clk);
    ctrlClass = c; brFunc3 = f; pcIn = pc; rs1Val = a; rs2Val = b; immVal = imm;
    @(negedge clk);
  endtask

  // full comparison against the model, tagged by the requirement that the class exercises
  task automatic checkAll(input string req);
    logic [31:0] expNext;
    logic        expTaken;
    expTaken = refTaken(ctrlClass, brFunc3, rs1Val, rs2Val);
    expNext  = refNext(ctrlClass, brFunc3, pcIn, rs1Val, rs2Val, immVal);
    checkBit (req, "taken", taken, expTaken);
    checkWord(req, "nextPc", nextPc, expNext);
    checkWord("R8", "linkVal", linkVal, pcIn + 32'd4);
    checkBit ("R9", "addrMisaligned", addrMisaligned, expTaken && (expNext[1:0] != 2'b00));
    checkBit ("R11", "condIllegal", condIllegal, refIllegal(ctrlClass, brFunc3));
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : stim
    int unsigned seed;
    string tag;
    ctrlClass = 2'b00; brFunc3 = 3'b000; pcIn = '0; rs1Val = '0; rs2Val = '0; immVal = '0;
    @(negedge clk);
    // initial state: sequential with zero inputs
    checkWord("R1", "init nextPc", nextPc, 32'd4);
    checkBit ("R1", "init taken", taken, 1'b0);

    // R1 sequential with unaligned immediate: no effect
    apply(2'b00, 3'b000, 32'h0000_1000, 32'h5, 32'h5, 32'h0000_0002);
    checkAll("R1");
    // R2 equal / not equal
    apply(2'b01, 3'b000, 32'h0000_2000, 32'h1234, 32'h1234, 32'hFFFF_FFF0); checkAll("R2");
    apply(2'b01, 3'b001, 32'h0000_2000, 32'h1234, 32'h1234, 32'h0000_0010); checkAll("R2");
    apply(2'b01, 3'b001, 32'h0000_2000, 32'h1234, 32'h1235, 32'h0000_0010); checkAll("R2");
    // R3 signed: 0x80000000 < 1 signed
    apply(2'b01, 3'b100, 32'h0000_3000, 32'h8000_0000, 32'h1, 32'h40); checkAll("R3");
    apply(2'b01, 3'b101, 32'h0000_3000, 32'h8000_0000, 32'h1, 32'h40); checkAll("R3");
    apply(2'b01, 3'b101, 32'h0000_3000, 32'h7, 32'h7, 32'h40);          checkAll("R3");
    // R4 unsigned: same pair reverses
    apply(2'b01, 3'b110, 32'h0000_3000, 32'h8000_0000, 32'h1, 32'h40); checkAll("R4");
    apply(2'b01, 3'b111, 32'h0000_3000, 32'h8000_0000, 32'h1, 32'h40); checkAll("R4");
    apply(2'b01, 3'b110, 32'h0000_3000, 32'h9, 32'h9, 32'h40);          checkAll("R4");
    // R5 taken with wraparound, R9 taken with halfword offset
    apply(2'b01, 3'b000, 32'hFFFF_FFF8, 32'h0, 32'h0, 32'h0000_0010); checkAll("R5");
    apply(2'b01, 3'b000, 32'h0000_4000, 32'h0, 32'h0, 32'h0000_0006); checkAll("R9");
    // R10 not-taken with halfword offset
    apply(2'b01, 3'b001, 32'h0000_4000, 32'h0, 32'h0, 32'h0000_0006);
    checkBit("R10", "not-taken misaligned", addrMisaligned, 1'b0);
    checkAll("R10");
    // R6 direct jump, aligned and halfword
    apply(2'b10, 3'b010, 32'h0000_5000, 32'h0, 32'h0, 32'hFFFF_F000); checkAll("R6");
    apply(2'b10, 3'b000, 32'h0000_5000, 32'h0, 32'h0, 32'h0000_0802); checkAll("R6");
    // R7 register jump, odd sum cleared, and halfword target
    apply(2'b11, 3'b000, 32'h0000_6000, 32'h0000_1001, 32'h0, 32'h0000_0004);
    checkBit("R7", "bit0 cleared", nextPc[0], 1'b0);
    checkAll("R7");
    apply(2'b11, 3'b000, 32'h0000_6000, 32'h0000_1003, 32'h0, 32'h0); checkAll("R7");
    // R11 reserved codes on branch, and the same codes on jumps
    apply(2'b01, 3'b010, 32'h0000_7000, 32'h3, 32'h3, 32'h20); checkAll("R11");
    apply(2'b01, 3'b011, 32'h0000_7000, 32'h3, 32'h4, 32'h20); checkAll("R11");
    apply(2'b11, 3'b011, 32'h0000_7000, 32'h100, 32'h4, 32'h20); checkAll("R11");
    // R8 link wraps
    apply(2'b10, 3'b000, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h8); checkAll("R8");

    // constrained random
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  c;
      logic [2:0]  f;
      logic [31:0] a, b, imm, pc;
      c   = 2'($urandom);
      f   = 3'($urandom);
      pc  = {$urandom} & 32'hFFFF_FFFC;
      a   = $urandom;
      b   = ($urandom_range(0, 3) == 0) ? a : $urandom;
      if ($urandom_range(0, 3) == 0) b = {~a[31], a[30:0]};
      imm = ($urandom_range(0, 1) == 0) ? 32'($signed(12'($urandom))) : {$urandom} & 32'hFFFF_FFFE;
      apply(c, f, pc, a, b, imm);
      case (c)
        2'b00: tag = "R1";
        2'b01: tag = (f[2:1] == 2'b00) ? "R2" : (f[2:1] == 2'b10) ? "R3" :
                     (f[2:1] == 2'b11) ? "R4" : "R11";
        2'b10: tag = "R6";
        default: tag = "R7";
      endcase
      checkAll(tag);
      if (c == 2'b01 && !taken) checkBit("R10", "rand not-taken misaligned", addrMisaligned, 1'b0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule